// File: doc/BRIEF.md
# Acquisition and Conversion Timing Generator

This block turns one accepted instruction into the timing for a sample/hold converter front end. A sequencer presents the instruction fields and pulses `start_i`. The generator then steps through up to four phases in a fixed order. An optional short auto-zero comes first. An optional wait for an external trigger follows. Then comes the sample/hold acquisition window, whose length depends on a 4-bit code and the resolution. Last is the conversion window. After the last conversion cycle it returns a single-cycle `done_o`.

Timing is either internal or triggered from outside. In internal mode the block drives the sync pin itself, as a strobe that is high during conversion. In external mode the pin is an input. It is passed through a two-flop synchroniser, and its rising edge releases the acquisition phase.

A separate long auto-zero command runs a standalone 8-cycle auto-zero and produces no done pulse. All pins are plain control and status signals. There is no data stream and so no valid/ready handshake: a start request is taken only in the idle state and is dropped otherwise, so back-pressure does not arise.

Top module: `acq_conv_timer`

## Requirements
- R1: After reset `az_o`, `sh_o`, `conv_o`, `sync_o`, `busy_o` and `done_o` are 0 and `sync_oe_o` is 1.
- R2: With `res8_i`=0 (12-bit plus sign), `sh_o` stays high for exactly 9 + 2·D consecutive cycles, where D is the unsigned value of `acq_code_i`.
- R3: With `res8_i`=1 (8-bit plus sign), `sh_o` stays high for exactly 2 + 2·D consecutive cycles.
- R4: `conv_o` rises in the cycle right after the last acquisition cycle and stays high for 13 cycles in 12-bit mode and 9 cycles in 8-bit mode.
- R5: With `az_each_i`=1, `az_o` is high for the 2 cycles right after the start edge, before acquisition; with `az_each_i`=0, no auto-zero runs and, in internal mode, `sh_o` rises in the first cycle after the start edge.
- R6: A `long_az_i` pulse in the idle state raises `az_o` and `busy_o` for exactly 8 cycles, with no acquisition, conversion or done; when `start_i` and `long_az_i` arrive together, the start wins and the long auto-zero is dropped.
- R7: With `ext_sync_i`=1, acquisition waits for a rising edge on `sync_in_i`; `sh_o` rises in the cycle after the third rising clock edge that follows the pin's rise, and never before it.
- R8: `sync_oe_o` equals the inverse of `ext_sync_i` captured with the last accepted start (1 means the block drives the pin); in internal mode `sync_o` is high exactly during the conversion cycles, and in external mode it stays 0.
- R9: `done_o` is high for exactly one cycle, the cycle right after the last conversion cycle, with `busy_o` already low.
- R10: A `start_i` pulse while `busy_o` is high has no effect: the phase lengths and the single done pulse of the running instruction are unchanged.
- R11: At most one of `az_o`, `sh_o`, `conv_o` is high in any cycle, and any of them high implies `busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request for one instruction, taken only while idle |
| long_az_i | input | 1 | Command for a standalone 8-cycle auto-zero, taken only while idle |
| acq_code_i | input | 4 | Acquisition length code D |
| res8_i | input | 1 | 1 = 8-bit plus sign, 0 = 12-bit plus sign |
| az_each_i | input | 1 | 1 = short auto-zero before the conversion |
| ext_sync_i | input | 1 | 1 = acquisition triggered by the sync pin |
| sync_in_i | input | 1 | Sync pin input value (asynchronous) |
| az_o | output | 1 | Auto-zero phase active |
| sh_o | output | 1 | Sample/hold acquisition phase active |
| conv_o | output | 1 | Conversion phase active |
| sync_o | output | 1 | Sync pin output value |
| sync_oe_o | output | 1 | Sync pin output enable |
| busy_o | output | 1 | An instruction or long auto-zero is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the phases are mutually exclusive and confined to busy time, that acquisition always leads directly into conversion, and that every conversion run has one of the two legal lengths. They also check that done is a single cycle following conversion and that the sync pin is never driven while it is an input. Only the bench scenarios can show that each acquisition length matches its code and resolution, and that the external edge releases acquisition after the right synchroniser delay. The same holds for the long auto-zero and its priority, and for a start request during a run being dropped.

// File: rtl/acq_timer_pkg.sv
package acq_timer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LAZ  = 3'd1,
    PH_SAZ  = 3'd2,
    PH_WAIT = 3'd3,
    PH_ACQ  = 3'd4,
    PH_CONV = 3'd5
  } phase_e;
endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/acq_len_calc.sv
module acq_len_calc #(
  parameter int CODE_W      = 4,
  parameter int CNT_W       = 6,
  parameter int ACQ_BASE_HI = 9,
  parameter int ACQ_BASE_LO = 2,
  parameter int CONV_HI     = 13,
  parameter int CONV_LO     = 9
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              res8_i,
  output logic [CNT_W-1:0]  acq_len_o,
  output logic [CNT_W-1:0]  conv_len_o
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] twice;

  always_comb begin
    base       = res8_i ? CNT_W'(ACQ_BASE_LO) : CNT_W'(ACQ_BASE_HI);
    twice      = CNT_W'(code_i) << 1;
    acq_len_o  = base + twice;
    conv_len_o = res8_i ? CNT_W'(CONV_LO) : CNT_W'(CONV_HI);
  end
endmodule

// File: rtl/acq_phase_seq.sv
module acq_phase_seq
  import acq_timer_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int AZ_SHORT = 2,
  parameter int AZ_LONG  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             long_az_i,
  input  logic             az_each_i,
  input  logic             ext_sync_i,
  input  logic             sync_rise_i,
  input  logic [CNT_W-1:0] acq_len_i,
  input  logic [CNT_W-1:0] conv_len_i,
  output phase_e           phase_o,
  output logic             ext_q_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] SAZ_LAST = CNT_W'(AZ_SHORT - 1);
  localparam logic [CNT_W-1:0] LAZ_LAST = CNT_W'(AZ_LONG - 1);

  phase_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] acq_len_q;
  logic [CNT_W-1:0] conv_len_q;
  logic             ext_q;
  logic             cnt_end;

  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      cnt_q      <= '0;
      acq_len_q  <= '0;
      conv_len_q <= '0;
      ext_q      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        PH_IDLE: begin
          if (start_i) begin
            acq_len_q  <= acq_len_i;
            conv_len_q <= conv_len_i;
            ext_q      <= ext_sync_i;
            if (az_each_i) begin
              state_q <= PH_SAZ;
              cnt_q   <= SAZ_LAST;
            end else if (ext_sync_i) begin
              state_q <= PH_WAIT;
            end else begin
              state_q <= PH_ACQ;
              cnt_q   <= acq_len_i - ONE;
            end
          end else if (long_az_i) begin
            state_q <= PH_LAZ;
            cnt_q   <= LAZ_LAST;
          end
        end
        PH_LAZ: begin
          if (cnt_end) state_q <= PH_IDLE;
          else         cnt_q   <= cnt_q - ONE;
        end
        PH_SAZ: begin
          if (cnt_end) begin
            if (ext_q) begin
              state_q <= PH_WAIT;
            end else begin
              state_q <= PH_ACQ;
              cnt_q   <= acq_len_q - ONE;
            end
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        PH_WAIT: begin
          if (sync_rise_i) begin
            state_q <= PH_ACQ;
            cnt_q   <= acq_len_q - ONE;
          end
        end
        PH_ACQ: begin
          if (cnt_end) begin
            state_q <= PH_CONV;
            cnt_q   <= conv_len_q - ONE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        PH_CONV: begin
          if (cnt_end) begin
            state_q <= PH_IDLE;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = state_q;
  assign ext_q_o = ext_q;
endmodule

// File: rtl/acq_conv_timer.sv
module acq_conv_timer
  import acq_timer_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int ACQ_BASE_HI = 9,
  parameter int ACQ_BASE_LO = 2,
  parameter int CONV_HI     = 13,
  parameter int CONV_LO     = 9,
  parameter int AZ_SHORT    = 2,
  parameter int AZ_LONG     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              long_az_i,
  input  logic [CODE_W-1:0] acq_code_i,
  input  logic              res8_i,
  input  logic              az_each_i,
  input  logic              ext_sync_i,
  input  logic              sync_in_i,
  output logic              az_o,
  output logic              sh_o,
  output logic              conv_o,
  output logic              sync_o,
  output logic              sync_oe_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_LEN = ACQ_BASE_HI + 2 * ((1 << CODE_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] acq_len;
  logic [CNT_W-1:0] conv_len;
  logic             sync_rise;
  logic             ext_q;
  phase_e           phase;

  acq_len_calc #(
    .CODE_W(CODE_W), .CNT_W(CNT_W),
    .ACQ_BASE_HI(ACQ_BASE_HI), .ACQ_BASE_LO(ACQ_BASE_LO),
    .CONV_HI(CONV_HI), .CONV_LO(CONV_LO)
  ) u_len (
    .code_i(acq_code_i), .res8_i(res8_i),
    .acq_len_o(acq_len), .conv_len_o(conv_len)
  );

  acq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sync_in_i), .rise_o(sync_rise)
  );

  acq_phase_seq #(
    .CNT_W(CNT_W), .AZ_SHORT(AZ_SHORT), .AZ_LONG(AZ_LONG)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_az_i(long_az_i),
    .az_each_i(az_each_i), .ext_sync_i(ext_sync_i), .sync_rise_i(sync_rise),
    .acq_len_i(acq_len), .conv_len_i(conv_len),
    .phase_o(phase), .ext_q_o(ext_q), .done_o(done_o)
  );

  assign az_o      = (phase == PH_LAZ) || (phase == PH_SAZ);
  assign sh_o      = (phase == PH_ACQ);
  assign conv_o    = (phase == PH_CONV);
  assign busy_o    = (phase != PH_IDLE);
  assign sync_oe_o = ~ext_q;
  assign sync_o    = conv_o & ~ext_q;
endmodule

// File: rtl/acq_conv_timer_chk.sv
module acq_conv_timer_chk #(
  parameter int CONV_HI = 13,
  parameter int CONV_LO = 9
) (
  input logic clk,
  input logic rst_n,
  input logic az_o,
  input logic sh_o,
  input logic conv_o,
  input logic sync_o,
  input logic sync_oe_o,
  input logic busy_o,
  input logic done_o
);
  logic [7:0] conv_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      conv_run_q <= '0;
    else if (conv_o) conv_run_q <= conv_run_q + 8'd1;
    else             conv_run_q <= '0;
  end

  // R11
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({az_o, sh_o, conv_o}));

  // R11
  phase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (az_o || sh_o || conv_o) |-> busy_o);

  // R4
  conv_after_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> $past(sh_o));

  // R4
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> (conv_run_q == 8'(CONV_HI) || conv_run_q == 8'(CONV_LO)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_follows_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(conv_o) && !busy_o));

  // R8
  sync_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe_o |-> !sync_o);
endmodule

bind acq_conv_timer acq_conv_timer_chk #(.CONV_HI(CONV_HI), .CONV_LO(CONV_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .az_o(az_o), .sh_o(sh_o), .conv_o(conv_o),
  .sync_o(sync_o), .sync_oe_o(sync_oe_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/acq_conv_timer_tb.sv
module acq_conv_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       long_az_i = 1'b0;
  logic [3:0] acq_code_i = '0;
  logic       res8_i = 1'b0;
  logic       az_each_i = 1'b0;
  logic       ext_sync_i = 1'b0;
  logic       sync_in_i = 1'b0;
  logic az_o, sh_o, conv_o, sync_o, sync_oe_o, busy_o, done_o;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  acq_conv_timer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_az_i(long_az_i),
    .acq_code_i(acq_code_i), .res8_i(res8_i), .az_each_i(az_each_i),
    .ext_sync_i(ext_sync_i), .sync_in_i(sync_in_i),
    .az_o(az_o), .sh_o(sh_o), .conv_o(conv_o), .sync_o(sync_o),
    .sync_oe_o(sync_oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One instruction; expected timeline computed from the requirements.
  task automatic run_one(input int code, input bit r8, input bit aze, input bit ext);
    int a_len, l_len, c_len, p_off, t, n_az, n_sh, n_conv, n_sync, done_t, first_sh;
    bit bad;
    a_len = aze ? 2 : 0;
    l_len = r8 ? (2 + 2 * code) : (9 + 2 * code);
    c_len = r8 ? 9 : 13;
    p_off = a_len + (ext ? 6 : 0);  // pin raised after sample a_len+3, 3 edges to release
    n_az = 0; n_sh = 0; n_conv = 0; n_sync = 0; done_t = -1; first_sh = -1; bad = 0;
    @(negedge clk);
    acq_code_i = 4'(code); res8_i = r8; az_each_i = aze; ext_sync_i = ext;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    while (t < 200 && done_t < 0) begin
      if (az_o != (t < a_len)) bad = 1;
      if (sh_o != (t >= p_off && t < p_off + l_len)) bad = 1;
      if (conv_o != (t >= p_off + l_len && t < p_off + l_len + c_len)) bad = 1;
      if (busy_o != (t < p_off + l_len + c_len)) bad = 1;
      if (int'(az_o) + int'(sh_o) + int'(conv_o) > 1) bad = 1;
      if (az_o) n_az++;
      if (sh_o) n_sh++;
      if (conv_o) n_conv++;
      if (sync_o) n_sync++;
      if (sh_o && first_sh < 0) first_sh = t;
      if (done_o) done_t = t;
      if (ext && t == a_len + 3) sync_in_i = 1'b1;
      t++;
      @(negedge clk);
    end
    sync_in_i = 1'b0;
    check(n_sh == l_len, r8 ? "R3 acq length" : "R2 acq length", n_sh, l_len);
    check(n_conv == c_len, "R4 conv length", n_conv, c_len);
    check(n_az == a_len, "R5 auto-zero length", n_az, a_len);
    check(first_sh == p_off, ext ? "R7 acq start after sync edge" : "R5 acq start", first_sh, p_off);
    check(done_t == p_off + l_len + c_len, "R9 done position", done_t, p_off + l_len + c_len);
    check(!done_o, "R9 done one cycle", int'(done_o), 0);
    check(!bad, "R11 phase timeline", int'(bad), 0);
    check(n_sync == (ext ? 0 : c_len), "R8 sync strobe", n_sync, ext ? 0 : c_len);
    check(sync_oe_o == !ext, "R8 sync output enable", int'(sync_oe_o), int'(!ext));
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    int n_az, n_sh, n_conv, n_done, n_busy, n_sync;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({az_o, sh_o, conv_o, sync_o, busy_o, done_o} == 6'b0, "R1 reset outputs",
          int'({az_o, sh_o, conv_o, sync_o, busy_o, done_o}), 0);
    check(sync_oe_o == 1'b1, "R1 reset sync enable", int'(sync_oe_o), 1);

    // R2 R3 R4 R5 R7 R8 R9 R11: sweep every code, resolution and mode
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 16; c++) begin
        run_one(c, m[0], m[1], m[2]);
      end
    end

    // R6: standalone long auto-zero
    @(negedge clk);
    long_az_i = 1'b1;
    @(negedge clk);
    long_az_i = 1'b0;
    n_az = 0; n_sh = 0; n_conv = 0; n_done = 0; n_busy = 0;
    for (int i = 0; i < 20; i++) begin
      if (az_o) n_az++;
      if (sh_o) n_sh++;
      if (conv_o) n_conv++;
      if (done_o) n_done++;
      if (busy_o) n_busy++;
      @(negedge clk);
    end
    check(n_az == 8, "R6 long auto-zero length", n_az, 8);
    check(n_busy == 8, "R6 long auto-zero busy", n_busy, 8);
    check(n_sh + n_conv + n_done == 0, "R6 no conversion", n_sh + n_conv + n_done, 0);

    // R6: start and long auto-zero together, start wins
    acq_code_i = 4'd0; res8_i = 1'b0; az_each_i = 1'b0; ext_sync_i = 1'b0;
    start_i = 1'b1; long_az_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; long_az_i = 1'b0;
    n_az = 0; n_sh = 0; n_done = 0;
    for (int i = 0; i < 40; i++) begin
      if (az_o) n_az++;
      if (sh_o) n_sh++;
      if (done_o) n_done++;
      @(negedge clk);
    end
    check(n_az == 0, "R6 priority no auto-zero", n_az, 0);
    check(n_sh == 9, "R6 priority acq runs", n_sh, 9);
    check(n_done == 1, "R6 priority done", n_done, 1);

    // R10: start requests while busy are dropped
    acq_code_i = 4'd5; res8_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n_sh = 0; n_conv = 0; n_done = 0; n_sync = 0;
    for (int i = 0; i < 100; i++) begin
      if (i == 3 || i == 25) begin
        acq_code_i = 4'd15; res8_i = 1'b1; az_each_i = 1'b1; ext_sync_i = 1'b1;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (sh_o) n_sh++;
      if (conv_o) n_conv++;
      if (done_o) n_done++;
      if (sync_o) n_sync++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n_sh == 19, "R10 acq unchanged", n_sh, 19);
    check(n_conv == 13, "R10 conv unchanged", n_conv, 13);
    check(n_done == 1, "R10 single done", n_done, 1);
    check(n_sync == 13, "R10 mode unchanged", n_sync, 13);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule